// File: doc/BRIEF.md
# SPI Boot-Flash Command Guard

This block sits on the SPI bus between a host and its boot flash. Toward the host it acts as a slave, toward the flash as a master. After reset the flash is cut off from the host: no chip select and no clock reach it. The block waits for the result of an external firmware-signature check. A passing result opens the path for good. A failing result raises the alert and keeps the path shut until the next reset.

With the path open, every transaction is watched. The block treats the first eight bits after chip select falls as the opcode, sent MSB first in SPI mode 0, and holds the flash clock quiet while they arrive. On the eighth host rising edge it looks up the opcode in a 256-entry permission bitmap. It then sends the flash either the host's opcode or the harmless read-status opcode 0x05 as a fast burst of eight clock pulses. The burst fits inside the host's next bit time. After the burst the flash clock and data follow the host directly, so the host clock is never stalled.

Each substitution raises a sticky alert and increments a saturating counter. The bitmap is written through a one-bit register port, and a lock input freezes it until reset.

Top module: `spi_cmd_guard`

## Requirements
- R1: After reset, f_csn is 1, f_sclk is 0, h_miso is 0, alert is 0, sub_count is 0, and every bitmap entry reads as denied. An opcode sent with no bitmap writes is therefore substituted.
- R2: Until a passing signature result arrives, host activity produces no flash clock pulses and f_csn stays 1.
- R3: A cycle with sig_done=1 and sig_ok=1, while the block is still waiting, opens the path. Chip-select falls after that start forwarded transactions.
- R4: A cycle with sig_done=1 and sig_ok=0, while waiting, sets alert. The path then stays closed, and a later passing result is ignored until reset.
- R5: When bitmap entry [opcode] is 1, the flash receives exactly the host's bit stream, MSB first, with the same number of clock pulses.
- R6: When bitmap entry [opcode] is 0, the flash receives 0x05 in place of the opcode, followed by the host's remaining bits unchanged. The alert sets and sub_count increments.
- R7: No flash clock pulse occurs while the host sends the eight opcode bits. All eight flash-side opcode bits are clocked before the host's ninth rising edge, provided a host bit lasts at least 20 system clocks.
- R8: cfg_we writes cfg_allow into bitmap entry cfg_idx. After cfg_lock has been high for one cycle, writes are ignored until reset.
- R9: sub_count increments by one per substitution and holds at its maximum value without wrapping.
- R10: Chip-select rising returns the transaction to idle, whatever bit count was reached. A transaction shorter than eight bits gives no flash clock pulses and no count, and the next transaction decodes a fresh opcode.
- R11: h_miso equals f_miso while the path is open and is 0 otherwise.
- R12: alert, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI bus |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_done | input | 1 | Signature check result is valid this cycle |
| sig_ok | input | 1 | Signature check passed (qualified by sig_done) |
| cfg_we | input | 1 | Bitmap write strobe |
| cfg_idx | input | OP_W | Opcode whose permission bit is written |
| cfg_allow | input | 1 | Permission value to write (1 = permitted) |
| cfg_lock | input | 1 | Freeze the bitmap until reset |
| h_sclk | input | 1 | Host SPI clock |
| h_csn | input | 1 | Host chip select, active low |
| h_mosi | input | 1 | Host data toward flash |
| h_miso | output | 1 | Flash data returned to host |
| f_sclk | output | 1 | SPI clock toward flash |
| f_csn | output | 1 | Chip select toward flash, active low |
| f_mosi | output | 1 | Data toward flash |
| f_miso | input | 1 | Data from flash |
| alert | output | 1 | Sticky alert: failed signature or substituted opcode |
| sub_count | output | CNT_W | Saturating count of substituted opcodes |

## Verification
The bench goes after the points where a guard quietly lets damage through. The first is a denied opcode reaching the flash: a design with a reversed bitmap index or bit order would forward a page program or erase. The second is loss of bit alignment after the opcode: a design whose replay burst overran the host's ninth edge would shift every address bit. A design that kept the opcode bit count across chip-select rising would decode garbage after an aborted short transfer. The bench also tests bitmap writes made after lock, a failed signature followed by a passing one, and a counter pushed past its maximum, since each of these leaves a hole open that is easy to miss.

// File: rtl/spi_cmd_guard.sv
module spi_cmd_guard #(
  parameter int OP_W = 8,
  parameter int CNT_W = 8,
  parameter int SYNC_N = 2,
  parameter logic [OP_W-1:0] SAFE_OP = 'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_done,
  input  logic             sig_ok,
  input  logic             cfg_we,
  input  logic [OP_W-1:0]  cfg_idx,
  input  logic             cfg_allow,
  input  logic             cfg_lock,
  input  logic             h_sclk,
  input  logic             h_csn,
  input  logic             h_mosi,
  output logic             h_miso,
  output logic             f_sclk,
  output logic             f_csn,
  output logic             f_mosi,
  input  logic             f_miso,
  output logic             alert,
  output logic [CNT_W-1:0] sub_count
);
  localparam int NUM_OPS = 1 << OP_W;
  localparam int BIT_W = $clog2(OP_W);
  localparam int BURST_W = BIT_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OP_W - 1);
  localparam logic [BURST_W-1:0] LAST_PULSE = BURST_W'(2 * OP_W - 1);

  typedef enum logic [1:0] {G_WAIT, G_OPEN, G_FAIL} gate_t;
  typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_BURST, PH_PASS} phase_t;

  gate_t gate;
  phase_t ph;

  logic [SYNC_N-1:0] sclk_sync, csn_sync, mosi_sync;
  logic s_sclk, s_csn, s_mosi, sclk_prev, csn_prev;
  logic sclk_rise, csn_fall;

  logic [NUM_OPS-1:0] allow_map;
  logic locked;

  logic [OP_W-1:0] op_sr, out_op;
  logic [OP_W-1:0] op_next;
  logic [BIT_W-1:0] bit_cnt;
  logic [BURST_W-1:0] bcnt;
  logic [BIT_W-1:0] burst_idx;
  logic op_done, deny_evt;
  logic f_sclk_d, f_mosi_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      csn_sync  <= '1;
      mosi_sync <= '0;
      sclk_prev <= 1'b0;
      csn_prev  <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_N-2:0], h_sclk};
      csn_sync  <= {csn_sync[SYNC_N-2:0], h_csn};
      mosi_sync <= {mosi_sync[SYNC_N-2:0], h_mosi};
      sclk_prev <= s_sclk;
      csn_prev  <= s_csn;
    end
  end

  assign s_sclk = sclk_sync[SYNC_N-1];
  assign s_csn  = csn_sync[SYNC_N-1];
  assign s_mosi = mosi_sync[SYNC_N-1];
  assign sclk_rise = s_sclk & ~sclk_prev;
  assign csn_fall  = csn_prev & ~s_csn;

  always_ff @(posedge clk) begin
    if (!rst_n)
      gate <= G_WAIT;
    else if (gate == G_WAIT && sig_done)
      gate <= sig_ok ? G_OPEN : G_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allow_map <= '0;
      locked <= 1'b0;
    end else begin
      if (cfg_lock) locked <= 1'b1;
      if (cfg_we && !locked) allow_map[cfg_idx] <= cfg_allow;
    end
  end

  assign op_next  = {op_sr[OP_W-2:0], s_mosi};
  assign op_done  = (ph == PH_OPC) && !s_csn && sclk_rise && (bit_cnt == LAST_BIT);
  assign deny_evt = op_done && !allow_map[op_next];

  always_ff @(posedge clk) begin
    if (!rst_n || s_csn) begin
      ph <= PH_IDLE;
      bit_cnt <= '0;
      bcnt <= '0;
      op_sr <= '0;
      out_op <= '0;
    end else begin
      case (ph)
        PH_IDLE:
          if (csn_fall && gate == G_OPEN) begin
            ph <= PH_OPC;
            bit_cnt <= '0;
          end
        PH_OPC:
          if (sclk_rise) begin
            op_sr <= op_next;
            if (bit_cnt == LAST_BIT) begin
              ph <= PH_BURST;
              bcnt <= '0;
              out_op <= allow_map[op_next] ? op_next : SAFE_OP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        PH_BURST:
          if (bcnt == LAST_PULSE) ph <= PH_PASS;
          else bcnt <= bcnt + 1'b1;
        default: ph <= PH_PASS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert <= 1'b0;
      sub_count <= '0;
    end else begin
      if (deny_evt || (gate == G_WAIT && sig_done && !sig_ok)) alert <= 1'b1;
      if (deny_evt && sub_count != '1) sub_count <= sub_count + 1'b1;
    end
  end

  assign burst_idx = LAST_BIT - bcnt[BURST_W-1:1];

  always_comb begin
    case (ph)
      PH_BURST: begin f_sclk_d = bcnt[0]; f_mosi_d = out_op[burst_idx]; end
      PH_PASS:  begin f_sclk_d = s_sclk;  f_mosi_d = s_mosi; end
      default:  begin f_sclk_d = 1'b0;    f_mosi_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_csn <= 1'b1;
      f_sclk <= 1'b0;
      f_mosi <= 1'b0;
    end else begin
      f_csn <= (ph == PH_IDLE);
      f_sclk <= f_sclk_d;
      f_mosi <= f_mosi_d;
    end
  end

  assign h_miso = (gate == G_OPEN) & f_miso;

  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) gate != G_OPEN |-> f_csn && !f_sclk); // R2
  AST_FAIL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) gate == G_FAIL |-> alert && f_csn); // R4
  AST_DENY_ALERT: assert property (@(posedge clk) disable iff (!rst_n) deny_evt |=> alert); // R6
  AST_OPC_SILENT: assert property (@(posedge clk) disable iff (!rst_n) ph == PH_OPC |=> !f_sclk); // R7
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(allow_map)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) sub_count != $past(sub_count) |-> sub_count == CNT_W'($past(sub_count) + 1'b1)); // R9
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) s_csn |=> ph == PH_IDLE); // R10
  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) alert |=> alert); // R12
endmodule

// File: tb/spi_cmd_guard_bench.sv
module spi_cmd_guard_bench;
  localparam int HALF = 12;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig_done = 0, sig_ok = 0, cfg_we = 0, cfg_allow = 0, cfg_lock = 0;
  logic [7:0] cfg_idx = '0;
  logic h_sclk = 0, h_csn = 1, h_mosi = 0, f_miso = 1;
  logic h_miso, f_sclk, f_csn, f_mosi, alert;
  logic [CW-1:0] sub_count;

  int checks = 0, errors = 0;
  int ncap = 0, nclk_any = 0;
  logic [63:0] cap = '0;
  bit fcs_seen = 0, done = 0;
  bit model_allow [256];
  int exp_cnt = 0;

  localparam logic [31:0] VEC [6] = '{32'h03123456, 32'h02A5A5A5, 32'h9F000000,
                                      32'hD80F0F0F, 32'h0BFFFF00, 32'hC7C3C3C3};

  spi_cmd_guard #(.CNT_W(CW)) u_spi_cmd_guard (
    .clk(clk), .rst_n(rst_n), .sig_done(sig_done), .sig_ok(sig_ok),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_allow(cfg_allow), .cfg_lock(cfg_lock),
    .h_sclk(h_sclk), .h_csn(h_csn), .h_mosi(h_mosi), .h_miso(h_miso),
    .f_sclk(f_sclk), .f_csn(f_csn), .f_mosi(f_mosi), .f_miso(f_miso),
    .alert(alert), .sub_count(sub_count));

  always #10 clk = ~clk;

  always @(posedge f_sclk) begin
    nclk_any++;
    if (!f_csn) begin cap = {cap[62:0], f_mosi}; ncap++; end
  end
  always @(negedge f_csn) fcs_seen = 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; clks(4); rst_n = 1; clks(2);
    foreach (model_allow[i]) model_allow[i] = 0;
    exp_cnt = 0;
  endtask

  task automatic sig(input logic ok);
    sig_done = 1; sig_ok = ok; clks(1); sig_done = 0; sig_ok = 0; clks(2);
  endtask

  task automatic wr(input logic [7:0] idx, input logic v);
    cfg_we = 1; cfg_idx = idx; cfg_allow = v; clks(1); cfg_we = 0; clks(1);
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, input logic [7:0] exp_op, input bit r7);
    ncap = 0; nclk_any = 0; cap = '0; fcs_seen = 0;
    h_csn = 0; clks(HALF);
    for (int b = 0; b < nbits; b++) begin
      h_mosi = word[31-b];
      clks(HALF);
      if (r7 && b == 8) begin
        check("R7 opcode burst done before ninth edge", ncap, 8);
        check("R7 flash opcode value", cap[7:0], exp_op);
      end
      h_sclk = 1;
      if (r7 && b == 7) check("R7 flash clock silent during opcode", nclk_any, 0);
      clks(HALF);
      h_sclk = 0;
    end
    clks(HALF); h_csn = 1; clks(8);
  endtask

  task automatic run_op(input logic [31:0] word, input string req);
    logic [7:0] op;
    logic [31:0] expw;
    op = word[31:24];
    expw = model_allow[op] ? word : {8'h05, word[23:0]};
    if (!model_allow[op] && exp_cnt < 7) exp_cnt++;
    xfer(word, 32, expw[31:24], 1);
    check({req, " stream"}, cap[31:0], expw);
    check({req, " bit count"}, ncap, 32);
    check("R9 counter", sub_count, exp_cnt);
  endtask

  initial begin
    do_reset();
    check("R1 f_csn", f_csn, 1);
    check("R1 f_sclk", f_sclk, 0);
    check("R1 h_miso", h_miso, 0);
    check("R1 alert", alert, 0);
    check("R1 sub_count", sub_count, 0);

    xfer(32'h03000000, 32, 8'h00, 0);
    check("R2 no flash clocks before open", nclk_any, 0);
    check("R2 no flash select before open", fcs_seen, 0);
    check("R11 h_miso gated while closed", h_miso, 0);

    wr(8'h03, 1); model_allow[8'h03] = 1;
    wr(8'h0B, 1); model_allow[8'h0B] = 1;
    wr(8'h9F, 1); model_allow[8'h9F] = 1;
    sig(1);
    check("R11 h_miso follows f_miso 1", h_miso, 1);
    f_miso = 0; #1;
    check("R11 h_miso follows f_miso 0", h_miso, 0);
    f_miso = 1;
    check("R12 alert clear before any denial", alert, 0);

    for (int v = 0; v < 6; v++) begin
      run_op(VEC[v], model_allow[VEC[v][31:24]] ? "R5 R3 permitted" : "R6 substituted");
      check("R6 R12 alert state", alert, exp_cnt != 0);
    end

    wr(8'hD8, 1); model_allow[8'hD8] = 1;
    run_op(32'hD8ABCDEF, "R8 write takes effect");
    cfg_lock = 1; clks(1); cfg_lock = 0; clks(1);
    wr(8'hD8, 0);
    wr(8'h02, 1);
    run_op(32'hD8111111, "R8 locked entry kept");
    run_op(32'h02222222, "R8 locked write ignored");

    xfer(32'h02000000, 5, 8'h00, 0);
    check("R10 short transfer no flash clocks", nclk_any, 0);
    check("R10 short transfer no count", sub_count, exp_cnt);
    run_op(32'h03445566, "R10 fresh opcode after abort");

    for (int k = 0; k < 4; k++) run_op(32'h20778899, "R9 R6 saturation");
    check("R9 held at max", sub_count, 7);
    check("R12 alert still set", alert, 1);

    do_reset();
    check("R12 alert cleared by reset", alert, 0);
    sig(0);
    check("R4 alert on failed signature", alert, 1);
    sig(1);
    xfer(32'h03000000, 32, 8'h00, 0);
    check("R4 path stays closed", nclk_any, 0);
    check("R4 no flash select", fcs_seen, 0);
    check("R11 h_miso gated after fail", h_miso, 0);

    do_reset();
    sig(1);
    run_op(32'h03010203, "R1 bitmap denied after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule